// File: doc/BRIEF.md
# Tiled Image Address Generator

This block produces memory addresses for an image kept in a tiled layout. The image is cut into square tiles that follow one another in raster order. Inside each tile the elements are reordered along a bit-interleaving curve in which every X coordinate bit is XORed with the Y bit it is paired with. The reordering moves whole elements and never changes their contents, so the same mapping serves any element size. Software supplies the element size in bytes.

Two layouts are supported. In pixel layout a tile holds 16x16 elements. In block layout a tile holds 4x4 compressed blocks, and each block counts as one element.

The block has two independent paths. The conversion path turns a single (x, y) coordinate into an address one cycle later. The walk path sweeps a whole image in raster order, x fastest, and offers one address per element through a valid/ready handshake. It raises a one-cycle done pulse after the last element has been taken.

Top module: `tiled_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `cvt_out_valid` and `walk_done` are all 0.
- R2: In pixel layout (`cfg_block_mode`=0), tiles are 16x16. The intra-tile index is 8 bits, listed from MSB to LSB as y3, x3^y3, y2, x2^y2, y1, x1^y1, y0, x0^y0, where x and y are the coordinates modulo 16. For example, (5,3) gives index 30 and (15,15) gives index 170.
- R3: In block layout (`cfg_block_mode`=1), tiles are 4x4 blocks of 16 elements. The 4-bit index, from MSB to LSB, is y1, x1^y1, y0, x0^y0. For example, (3,1) gives index 6.
- R4: The tile number is (y / tile side) * `cfg_width_tiles` + (x / tile side). Each tile occupies a contiguous run of elements-per-tile elements.
- R5: The address is `cfg_base` + (tile number * elements per tile + intra index) * `cfg_bpe`, for any element size.
- R6: The cycle after `cvt_valid` is high, `cvt_out_valid` is high and `cvt_addr` holds the address of (`cvt_x`, `cvt_y`) under the configuration present when `cvt_valid` was sampled. When `cvt_valid` is low, `cvt_out_valid` is low the next cycle.
- R7: A walk started by `walk_start` offers every element of a `cfg_width_tiles` x `cfg_height_tiles` tile image exactly once. It begins at (0,0) and steps x fastest, then y. Each element is offered on `out_x`, `out_y` and `out_addr`, and `out_addr` is the R5 address of that element.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_x`, `out_y` and `out_addr` hold their values.
- R9: The cycle after the last element is accepted, `walk_done` is high for exactly one cycle and `out_valid` is low.
- R10: A `walk_start` that arrives while a walk is in progress is ignored. The position, the address and the configuration captured at the start are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Byte address of the first element |
| cfg_width_tiles | input | 8 | Image width in tiles |
| cfg_height_tiles | input | 8 | Image height in tiles (used by the walk) |
| cfg_bpe | input | 5 | Bytes per element |
| cfg_block_mode | input | 1 | 0 = 16x16 pixel tiles, 1 = 4x4 compressed-block tiles |
| cvt_valid | input | 1 | Convert request |
| cvt_x | input | 12 | X coordinate to convert |
| cvt_y | input | 12 | Y coordinate to convert |
| cvt_out_valid | output | 1 | Converted address valid |
| cvt_addr | output | 32 | Converted address |
| walk_start | input | 1 | Begin a whole-image walk (captures configuration) |
| out_valid | output | 1 | Walk element offered |
| out_ready | input | 1 | Consumer accepts the offered element |
| out_x | output | 12 | X of the offered element |
| out_y | output | 12 | Y of the offered element |
| out_addr | output | 32 | Address of the offered element |
| walk_done | output | 1 | One-cycle pulse after the final element |

## Verification
The hardest situation to reach from the ports is a start request that lands in the middle of a walk while the consumer is stalling. The bench reaches it by accepting a few elements of a pixel-layout walk and then dropping `out_ready`. While stalled, it pulses `walk_start` with a different layout and base on the configuration inputs. It then checks that the offered position and address still follow the original walk, and it drains the rest of the walk under an irregular ready pattern. This drain also exercises the row wrap and the tile boundaries.

// File: rtl/tiled_addr_pkg.sv
package tiled_addr_pkg;

    localparam int WT_W    = 8;
    localparam int PIX_LG  = 4;
    localparam int BLK_LG  = 2;
    localparam int COORD_W = WT_W + PIX_LG;
    localparam int ADDR_W  = 32;
    localparam int BPE_W   = 5;
    localparam int PIX_IDX_W = 2 * PIX_LG;
    localparam int BLK_IDX_W = 2 * BLK_LG;

    typedef enum logic {
        LAYOUT_PIXEL = 1'b0,
        LAYOUT_BLOCK = 1'b1
    } layout_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [WT_W-1:0]   width_tiles;
        logic [WT_W-1:0]   height_tiles;
        logic [BPE_W-1:0]  bpe;
        layout_e           mode;
    } img_cfg_t;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } coord_t;

    function automatic logic [COORD_W-1:0] span_of(input logic [WT_W-1:0] tiles,
                                                   input layout_e mode);
        logic [COORD_W-1:0] t;
        t = COORD_W'(tiles);
        return (mode == LAYOUT_BLOCK) ? (t << BLK_LG) : (t << PIX_LG);
    endfunction

endpackage

// File: rtl/tile_swizzle.sv
module tile_swizzle
    import tiled_addr_pkg::*;
#(
    parameter int LG = 4
) (
    input  logic [LG-1:0]   ix,
    input  logic [LG-1:0]   iy,
    output logic [2*LG-1:0] idx
);
    generate
        for (genvar i = 0; i < LG; i++) begin : g_pair
            assign idx[2*i]   = ix[i] ^ iy[i];
            assign idx[2*i+1] = iy[i];
        end
    endgenerate
endmodule

// File: rtl/tile_addr_calc.sv
module tile_addr_calc
    import tiled_addr_pkg::*;
(
    input  coord_t            pos,
    input  img_cfg_t          cfg,
    output logic [ADDR_W-1:0] addr
);
    logic [PIX_IDX_W-1:0] pix_idx;
    logic [BLK_IDX_W-1:0] blk_idx;
    logic [ADDR_W-1:0]    tile_x, tile_y, tile_num, elem;

    tile_swizzle #(.LG(PIX_LG)) u_pix (
        .ix (pos.x[PIX_LG-1:0]),
        .iy (pos.y[PIX_LG-1:0]),
        .idx(pix_idx)
    );

    tile_swizzle #(.LG(BLK_LG)) u_blk (
        .ix (pos.x[BLK_LG-1:0]),
        .iy (pos.y[BLK_LG-1:0]),
        .idx(blk_idx)
    );

    always_comb begin
        if (cfg.mode == LAYOUT_BLOCK) begin
            tile_x = ADDR_W'(pos.x >> BLK_LG);
            tile_y = ADDR_W'(pos.y >> BLK_LG);
        end else begin
            tile_x = ADDR_W'(pos.x >> PIX_LG);
            tile_y = ADDR_W'(pos.y >> PIX_LG);
        end
        tile_num = tile_y * ADDR_W'(cfg.width_tiles) + tile_x;
        if (cfg.mode == LAYOUT_BLOCK)
            elem = (tile_num << BLK_IDX_W) | ADDR_W'(blk_idx);
        else
            elem = (tile_num << PIX_IDX_W) | ADDR_W'(pix_idx);
        addr = cfg.base + elem * ADDR_W'(cfg.bpe);
    end
endmodule

// File: rtl/tile_walker.sv
module tile_walker
    import tiled_addr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  img_cfg_t cfg_in,
    input  logic     ready,
    output logic     valid,
    output coord_t   pos,
    output img_cfg_t cfg_q,
    output logic     done
);
    typedef enum logic {WALK_IDLE, WALK_RUN} walk_state_e;

    walk_state_e        state;
    logic [COORD_W-1:0] last_x, last_y;
    logic               take, row_end, img_end;

    always_comb begin
        last_x  = span_of(cfg_q.width_tiles,  cfg_q.mode) - 1'b1;
        last_y  = span_of(cfg_q.height_tiles, cfg_q.mode) - 1'b1;
        valid   = (state == WALK_RUN);
        take    = valid && ready;
        row_end = (pos.x == last_x);
        img_end = row_end && (pos.y == last_y);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WALK_IDLE;
            pos   <= '0;
            cfg_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                WALK_IDLE: begin
                    if (start) begin
                        state <= WALK_RUN;
                        pos   <= '0;
                        cfg_q <= cfg_in;
                    end
                end
                WALK_RUN: begin
                    if (take) begin
                        if (img_end) begin
                            state <= WALK_IDLE;
                            done  <= 1'b1;
                        end else if (row_end) begin
                            pos.x <= '0;
                            pos.y <= pos.y + 1'b1;
                        end else begin
                            pos.x <= pos.x + 1'b1;
                        end
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen
    import tiled_addr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [WT_W-1:0]    cfg_width_tiles,
    input  logic [WT_W-1:0]    cfg_height_tiles,
    input  logic [BPE_W-1:0]   cfg_bpe,
    input  logic               cfg_block_mode,
    input  logic               cvt_valid,
    input  logic [COORD_W-1:0] cvt_x,
    input  logic [COORD_W-1:0] cvt_y,
    output logic               cvt_out_valid,
    output logic [ADDR_W-1:0]  cvt_addr,
    input  logic               walk_start,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [COORD_W-1:0] out_x,
    output logic [COORD_W-1:0] out_y,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               walk_done
);
    img_cfg_t          live_cfg, walk_cfg;
    coord_t            cvt_pos, walk_pos;
    logic [ADDR_W-1:0] cvt_next;

    always_comb begin
        live_cfg.base         = cfg_base;
        live_cfg.width_tiles  = cfg_width_tiles;
        live_cfg.height_tiles = cfg_height_tiles;
        live_cfg.bpe          = cfg_bpe;
        live_cfg.mode         = cfg_block_mode ? LAYOUT_BLOCK : LAYOUT_PIXEL;
        cvt_pos.x             = cvt_x;
        cvt_pos.y             = cvt_y;
    end

    tile_addr_calc u_cvt_calc (
        .pos (cvt_pos),
        .cfg (live_cfg),
        .addr(cvt_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cvt_out_valid <= 1'b0;
            cvt_addr      <= '0;
        end else begin
            cvt_out_valid <= cvt_valid;
            if (cvt_valid)
                cvt_addr <= cvt_next;
        end
    end

    tile_walker u_walker (
        .clk   (clk),
        .rst   (rst),
        .start (walk_start),
        .cfg_in(live_cfg),
        .ready (out_ready),
        .valid (out_valid),
        .pos   (walk_pos),
        .cfg_q (walk_cfg),
        .done  (walk_done)
    );

    tile_addr_calc u_walk_calc (
        .pos (walk_pos),
        .cfg (walk_cfg),
        .addr(out_addr)
    );

    assign out_x = walk_pos.x;
    assign out_y = walk_pos.y;
endmodule

// File: rtl/tiled_addr_chk.sv
module tiled_addr_chk
    import tiled_addr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cvt_valid,
    input logic               cvt_out_valid,
    input logic               walk_start,
    input logic               out_valid,
    input logic               out_ready,
    input logic [COORD_W-1:0] out_x,
    input logic [COORD_W-1:0] out_y,
    input logic [ADDR_W-1:0]  out_addr,
    input logic               walk_done
);
    assert_cvt_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
        cvt_valid |=> cvt_out_valid);

    assert_cvt_idle_follows_R6: assert property (@(posedge clk) disable iff (rst)
        !cvt_valid |=> !cvt_out_valid);

    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_x) && $stable(out_y) && $stable(out_addr)));

    assert_done_no_valid_R9: assert property (@(posedge clk) disable iff (rst)
        walk_done |-> !out_valid);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !walk_done);

    assert_accept_moves_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=>
            (!out_valid || out_x != $past(out_x) || out_y != $past(out_y)));

    assert_restart_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && walk_start) |=>
            ($stable(out_x) && $stable(out_y) && $stable(out_addr)));
endmodule

bind tiled_addr_gen tiled_addr_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cvt_valid    (cvt_valid),
    .cvt_out_valid(cvt_out_valid),
    .walk_start   (walk_start),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_x        (out_x),
    .out_y        (out_y),
    .out_addr     (out_addr),
    .walk_done    (walk_done)
);

// File: tb/test_tiled_addr_gen.sv
`timescale 1ns/1ps
module test_tiled_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_base = '0;
    logic [7:0]  cfg_width_tiles = 8'd1;
    logic [7:0]  cfg_height_tiles = 8'd1;
    logic [4:0]  cfg_bpe = 5'd1;
    logic        cfg_block_mode = 1'b0;
    logic        cvt_valid = 1'b0;
    logic [11:0] cvt_x = '0, cvt_y = '0;
    logic        cvt_out_valid;
    logic [31:0] cvt_addr;
    logic        walk_start = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [11:0] out_x, out_y;
    logic [31:0] out_addr;
    logic        walk_done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tiled_addr_gen i_tiled_addr_gen (.*);

    function automatic logic [31:0] ref_addr(int x, int y, int wt, int base, int bpe, bit blk);
        int lg, ix, iy, idx, tile;
        lg = blk ? 2 : 4;
        ix = x % (1 << lg);
        iy = y % (1 << lg);
        idx = 0;
        for (int i = 0; i < lg; i++) begin
            idx += (((ix >> i) ^ (iy >> i)) & 1) << (2 * i);
            idx += ((iy >> i) & 1) << (2 * i + 1);
        end
        tile = (y >> lg) * wt + (x >> lg);
        return 32'(base + ((tile << (2 * lg)) + idx) * bpe);
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(int base, int wt, int ht, int bpe, bit blk);
        cfg_base = 32'(base);
        cfg_width_tiles = 8'(wt);
        cfg_height_tiles = 8'(ht);
        cfg_bpe = 5'(bpe);
        cfg_block_mode = blk;
    endtask

    task automatic convert(int x, int y, output logic [31:0] a);
        @(negedge clk);
        cvt_x = 12'(x);
        cvt_y = 12'(y);
        cvt_valid = 1'b1;
        @(negedge clk);
        cvt_valid = 1'b0;
        check("R6", "cvt_out_valid", cvt_out_valid, 1);
        a = cvt_addr;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1", "out_valid", out_valid, 0);
        check("R1", "cvt_out_valid", cvt_out_valid, 0);
        check("R1", "walk_done", walk_done, 0);
    endtask

    task automatic t_pixel_index;
        logic [31:0] a;
        set_cfg(0, 4, 1, 1, 0);
        convert(5, 3, a);    check("R2", "idx(5,3)", a, 30);
        convert(15, 15, a);  check("R2", "idx(15,15)", a, 170);
        convert(0, 1, a);    check("R2", "idx(0,1)", a, 3);
        convert(1, 0, a);    check("R2", "idx(1,0)", a, 1);
        @(negedge clk);
        check("R6", "cvt_out_valid idle", cvt_out_valid, 0);
    endtask

    task automatic t_block_index;
        logic [31:0] a;
        set_cfg(0, 4, 1, 1, 1);
        convert(3, 1, a);    check("R3", "idx(3,1)", a, 6);
        convert(7, 1, a);    check("R3", "tile1(7,1)", a, 16 + 6);
        convert(2, 5, a);    check("R3", "tile4(2,5)", a, ref_addr(2, 5, 4, 0, 1, 1));
    endtask

    task automatic t_tile_and_bpe;
        logic [31:0] a;
        set_cfg(32'h1000, 3, 1, 4, 0);
        convert(20, 17, a);  check("R4", "tile4 addr", a, 32'h204C);
        set_cfg(32'h40, 5, 1, 12, 0);
        convert(70, 33, a);  check("R5", "bpe12", a, ref_addr(70, 33, 5, 32'h40, 12, 0));
        set_cfg(7, 9, 1, 16, 1);
        convert(35, 9, a);   check("R5", "block bpe16", a, ref_addr(35, 9, 9, 7, 16, 1));
    endtask

    task automatic drain(int wt, int ht, int base, int bpe, bit blk, int sx, int sy, int rmod);
        int ex = sx, ey = sy, k = 0, w, h;
        bit last = 0;
        w = wt << (blk ? 2 : 4);
        h = ht << (blk ? 2 : 4);
        while (!last) begin
            @(negedge clk);
            if (!out_valid) begin
                check("R7", "out_valid during walk", out_valid, 1);
                return;
            end
            if (out_x != 12'(ex) || out_y != 12'(ey)) begin
                check("R7", "x", out_x, ex);
                check("R7", "y", out_y, ey);
                return;
            end
            check("R7", "walk addr", out_addr, ref_addr(ex, ey, wt, base, bpe, blk));
            out_ready = (rmod == 0) || (k % rmod != 0);
            k++;
            if (out_ready) begin
                last = (ex == w - 1) && (ey == h - 1);
                if (ex == w - 1) begin ex = 0; ey++; end else ex++;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        check("R9", "walk_done", walk_done, 1);
        check("R9", "out_valid after end", out_valid, 0);
        @(negedge clk);
        check("R9", "done one cycle", walk_done, 0);
    endtask

    task automatic start_walk;
        @(negedge clk);
        walk_start = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
    endtask

    task automatic t_walk_pixel;
        set_cfg(32'h2000, 2, 2, 4, 0);
        start_walk();
        drain(2, 2, 32'h2000, 4, 0, 0, 0, 3);
    endtask

    task automatic t_walk_block;
        set_cfg(32'h80, 3, 2, 8, 1);
        start_walk();
        drain(3, 2, 32'h80, 8, 1, 0, 0, 0);
    endtask

    task automatic t_stall_and_restart;
        logic [31:0] held;
        set_cfg(32'h300, 1, 1, 2, 0);
        start_walk();
        out_ready = 1'b1;
        repeat (5) @(negedge clk);
        out_ready = 1'b0;
        check("R8", "x before stall", out_x, 5);
        held = out_addr;
        repeat (3) @(negedge clk);
        check("R8", "valid held", out_valid, 1);
        check("R8", "addr held", out_addr, held);
        set_cfg(32'h9000, 2, 2, 1, 1);
        walk_start = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        check("R10", "x kept", out_x, 5);
        check("R10", "y kept", out_y, 0);
        check("R10", "addr kept", out_addr, ref_addr(5, 0, 1, 32'h300, 2, 0));
        drain(1, 1, 32'h300, 2, 0, 5, 0, 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pixel_index();
        t_block_index();
        t_tile_and_bpe();
        t_walk_pixel();
        t_walk_block();
        t_stall_and_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule